// File: doc/BRIEF.md
# YCbCr 4:2:2 Output Formatter

The block turns a stream of 10-bit YCbCr 4:4:4 pixels into 4:2:2 video. Horizontal-active, vertical-blanking and field flags travel with each pixel. One of two output forms is chosen at run time. In the parallel form, a luma bus and a chroma bus carry one word each per pixel. In the serial form, a single 10-bit bus carries Cb, Y, Cr, Y at twice the pixel rate. Optionally, the block places four-word start-of-line and end-of-line timing codes around each active line. During blanking it can also substitute programmable fill words, so that downstream gain and clamp loops do not lock onto stray data.

The whole block runs on the fast word clock. A pixel-enable input `pix_ce` marks every other cycle as a pixel cycle; it must alternate high and low while video streams. Inputs are taken on pixel-enable edges. Each pixel is formatted into a word pair (chroma word first, luma word second). In parallel mode the pair goes to the two buses. In serial mode the pair is sent over two consecutive cycles. A three-word write port sets the controls.

Top module: `yc422_formatter`

## Requirements
- R1: While `rst_n` is low, `luma_o`, `chroma_o`, `mux_o`, `href_o`, `vref_o` and `fref_o` are all 0. The controls reset to parallel mode, codes off, fill off, chroma fill 0x200 and luma fill 0x040.
- R2: A pixel sampled on one pixel-enable edge appears after the second following pixel-enable edge. `luma_o` carries its Y. `chroma_o` carries its Cb when its line parity is even and its Cr when odd. Parity is 0 on a pixel whose flag is 1 while the previous pixel's was 0, and otherwise toggles per pixel. `href_o`, `vref_o` and `fref_o` carry its flags with the same delay.
- R3: Control bit 0 = 1 selects serial mode. After a pixel-enable edge `mux_o` holds the pixel's chroma word, and after the next edge its luma word, while `luma_o` and `chroma_o` read 0. In parallel mode `mux_o` reads 0.
- R4: Data words below 0x004 become 0x004, and words above 0x3FB become 0x3FB.
- R5: With control bit 2 set, every pixel that is not active (active means href 1 and vref 0) and is not a code slot carries the chroma fill word and the luma fill word instead of data.
- R6: With control bit 1 set, the two blanking pixels just before a pixel with href 1 carry the pairs (0x3FF, 0x000) and then (0x000, XY with H = 0).
- R7: With control bit 1 set, the two pixels just after the last href-1 pixel carry (0x3FF, 0x000) and then (0x000, XY with H = 1). End codes take priority over start codes.
- R8: XY has bit 9 set, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H and bits 1:0 = 0. F and V are the flags of the pixel that carries XY.
- R9: With control bit 1 clear, no code words are inserted, and those pixels follow R4/R5.
- R10: Address 0 holds the control bits, address 1 the chroma fill word and address 2 the luma fill word. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (twice the pixel rate) |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_ce | input | 1 | Pixel enable, high every other cycle |
| y_in | input | 10 | Luma of the input pixel |
| cb_in | input | 10 | Blue-difference chroma of the input pixel |
| cr_in | input | 10 | Red-difference chroma of the input pixel |
| href_in | input | 1 | Horizontal active flag |
| vref_in | input | 1 | Vertical blanking flag |
| fref_in | input | 1 | Field flag |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 2 | Control word address |
| cfg_wdata | input | 10 | Control write data |
| luma_o | output | 10 | Parallel-mode luma bus |
| chroma_o | output | 10 | Parallel-mode chroma bus |
| mux_o | output | 10 | Serial-mode word stream |
| href_o | output | 1 | Delayed horizontal flag |
| vref_o | output | 1 | Delayed vertical flag |
| fref_o | output | 1 | Delayed field flag |

## Verification
The bench sweeps all eight combinations of mode, code enable and fill enable over a short frame. The frame has even and odd line lengths, a vertical-blanking line and both field values. An odd line length catches a parity counter that is not restarted at line start: the next line would begin with Cr. Code slots sit on both sides of every line. A design that takes the start code one pixel late would overwrite the first active pixel. A wrong protection bit shows up as a bad XY under one of the four F/V combinations. Data swept through the ends of the range exposes missing clipping. The address-3 write would flip the mode or the fill words if it were decoded.

// File: rtl/yc422_pkg.sv
package yc422_pkg;
  localparam int unsigned YC_W = 10;
  typedef logic [YC_W-1:0] word_t;

  localparam word_t WORD_MAX    = '1;
  localparam word_t CLIP_LO     = word_t'(1 << (YC_W - 8));
  localparam word_t CLIP_HI     = WORD_MAX - CLIP_LO;
  localparam word_t FILL_C_RST  = word_t'(1 << (YC_W - 1));
  localparam word_t FILL_Y_RST  = word_t'(1 << (YC_W - 4));

  typedef struct packed {
    word_t y;
    word_t cb;
    word_t cr;
    logic  h;
    logic  v;
    logic  f;
  } pix_t;

  typedef enum logic [2:0] {
    SLOT_DATA, SLOT_EAV0, SLOT_EAV1, SLOT_SAV0, SLOT_SAV1
  } slot_e;

  function automatic word_t clip_word(word_t x);
    if (x < CLIP_LO)      return CLIP_LO;
    else if (x > CLIP_HI) return CLIP_HI;
    else                  return x;
  endfunction

  // protection word: marker bit, F, V, H, then four parity bits
  function automatic word_t trs_xy(logic f, logic v, logic h);
    word_t xy;
    xy           = '0;
    xy[YC_W-1]   = 1'b1;
    xy[YC_W-2]   = f;
    xy[YC_W-3]   = v;
    xy[YC_W-4]   = h;
    xy[YC_W-5]   = v ^ h;
    xy[YC_W-6]   = f ^ h;
    xy[YC_W-7]   = f ^ v;
    xy[YC_W-8]   = f ^ v ^ h;
    return xy;
  endfunction
endpackage

// File: rtl/yc422_cfg.sv
module yc422_cfg
  import yc422_pkg::*;
#(
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  word_t         wdata,
  output logic          mode_mux,
  output logic          code_en,
  output logic          fill_en,
  output word_t         fill_c,
  output word_t         fill_y
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_FC   = AW'(1);
  localparam logic [AW-1:0] A_FY   = AW'(2);

  logic  ctrl_ce, fc_ce, fy_ce;
  logic  mode_d, code_d, fill_d;
  word_t fc_d, fy_d;

  always_comb begin
    ctrl_ce = we && (addr == A_CTRL);
    fc_ce   = we && (addr == A_FC);
    fy_ce   = we && (addr == A_FY);
    mode_d  = ctrl_ce ? wdata[0] : mode_mux;
    code_d  = ctrl_ce ? wdata[1] : code_en;
    fill_d  = ctrl_ce ? wdata[2] : fill_en;
    fc_d    = fc_ce   ? wdata    : fill_c;
    fy_d    = fy_ce   ? wdata    : fill_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_mux <= 1'b0;
      code_en  <= 1'b0;
      fill_en  <= 1'b0;
      fill_c   <= FILL_C_RST;
      fill_y   <= FILL_Y_RST;
    end else begin
      mode_mux <= mode_d;
      code_en  <= code_d;
      fill_en  <= fill_d;
      fill_c   <= fc_d;
      fill_y   <= fy_d;
    end
  end
endmodule

// File: rtl/yc422_align.sv
module yc422_align
  import yc422_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  pix_t pix_in,
  output pix_t cur,
  output logic par,
  output logic h_p1,
  output logic h_p2,
  output logic h_m1,
  output logic h_m2
);
  pix_t s1_q, s2_q;
  logic par1_q, par2_q, hm1_q, hm2_q;
  logic par1_d;

  // parity restarts on the first href-high pixel of a line
  always_comb begin
    par1_d = (pix_in.h && !s1_q.h) ? 1'b0 : !par1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      par1_q <= 1'b0;
      par2_q <= 1'b0;
      hm1_q  <= 1'b0;
      hm2_q  <= 1'b0;
    end else if (ce) begin
      s1_q   <= pix_in;
      s2_q   <= s1_q;
      par1_q <= par1_d;
      par2_q <= par1_q;
      hm1_q  <= s2_q.h;
      hm2_q  <= hm1_q;
    end
  end

  assign cur  = s2_q;
  assign par  = par2_q;
  assign h_p1 = s1_q.h;
  assign h_p2 = pix_in.h;
  assign h_m1 = hm1_q;
  assign h_m2 = hm2_q;

  // R2: a line's first active pixel always starts with even parity
  p_par_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s1_q.h) |-> !par1_q);
endmodule

// File: rtl/yc422_trs.sv
module yc422_trs
  import yc422_pkg::*;
(
  input  logic  code_en,
  input  logic  h_cur,
  input  logic  h_p1,
  input  logic  h_p2,
  input  logic  h_m1,
  input  logic  h_m2,
  output slot_e slot
);
  // end codes win over start codes when a gap is too short for both
  always_comb begin
    if (!code_en || h_cur) slot = SLOT_DATA;
    else if (h_m1)         slot = SLOT_EAV0;
    else if (h_m2)         slot = SLOT_EAV1;
    else if (h_p1)         slot = SLOT_SAV1;
    else if (h_p2)         slot = SLOT_SAV0;
    else                   slot = SLOT_DATA;
  end
endmodule

// File: rtl/yc422_formatter.sv
module yc422_formatter
  import yc422_pkg::*;
#(
  parameter int unsigned CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic [YC_W-1:0]   y_in,
  input  logic [YC_W-1:0]   cb_in,
  input  logic [YC_W-1:0]   cr_in,
  input  logic              href_in,
  input  logic              vref_in,
  input  logic              fref_in,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [YC_W-1:0]   cfg_wdata,
  output logic [YC_W-1:0]   luma_o,
  output logic [YC_W-1:0]   chroma_o,
  output logic [YC_W-1:0]   mux_o,
  output logic              href_o,
  output logic              vref_o,
  output logic              fref_o
);
  logic  mode_mux, code_en, fill_en;
  word_t fill_c, fill_y;
  pix_t  pin, cur;
  logic  par, h_p1, h_p2, h_m1, h_m2;
  slot_e slot;

  word_t fmt_c, fmt_y;
  word_t c_q, y_q, mux_q, c_d, y_d, mux_d;
  logic  h_q, v_q, f_q;

  yc422_cfg #(.AW(CFG_AW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode_mux(mode_mux), .code_en(code_en), .fill_en(fill_en),
    .fill_c(fill_c), .fill_y(fill_y)
  );

  assign pin = '{y: y_in, cb: cb_in, cr: cr_in, h: href_in, v: vref_in, f: fref_in};

  yc422_align align_i (
    .clk(clk), .rst_n(rst_n), .ce(pix_ce), .pix_in(pin), .cur(cur), .par(par),
    .h_p1(h_p1), .h_p2(h_p2), .h_m1(h_m1), .h_m2(h_m2)
  );

  yc422_trs trs_i (
    .code_en(code_en), .h_cur(cur.h), .h_p1(h_p1), .h_p2(h_p2),
    .h_m1(h_m1), .h_m2(h_m2), .slot(slot)
  );

  // word pair for the pixel at the end of the alignment pipe
  always_comb begin
    unique case (slot)
      SLOT_EAV0, SLOT_SAV0: begin fmt_c = WORD_MAX; fmt_y = '0; end
      SLOT_EAV1: begin fmt_c = '0; fmt_y = trs_xy(cur.f, cur.v, 1'b1); end
      SLOT_SAV1: begin fmt_c = '0; fmt_y = trs_xy(cur.f, cur.v, 1'b0); end
      default: begin
        if (fill_en && !(cur.h && !cur.v)) begin
          fmt_c = fill_c;
          fmt_y = fill_y;
        end else begin
          fmt_c = clip_word(par ? cur.cr : cur.cb);
          fmt_y = clip_word(cur.y);
        end
      end
    endcase
  end

  // serial stream: chroma word on the pixel edge, luma word on the next
  always_comb begin
    c_d   = pix_ce ? fmt_c : c_q;
    y_d   = pix_ce ? fmt_y : y_q;
    mux_d = !mode_mux ? '0 : (pix_ce ? fmt_c : y_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      y_q   <= '0;
      mux_q <= '0;
      h_q   <= 1'b0;
      v_q   <= 1'b0;
      f_q   <= 1'b0;
    end else begin
      c_q   <= c_d;
      y_q   <= y_d;
      mux_q <= mux_d;
      if (pix_ce) begin
        h_q <= cur.h;
        v_q <= cur.v;
        f_q <= cur.f;
      end
    end
  end

  assign luma_o   = mode_mux ? '0 : y_q;
  assign chroma_o = mode_mux ? '0 : c_q;
  assign mux_o    = mux_q;
  assign href_o   = h_q;
  assign vref_o   = v_q;
  assign fref_o   = f_q;

  // R3: the serial stream needs a strictly alternating pixel enable
  p_ce_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);

  // R4: active words never enter the reserved code range
  p_active_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (href_o && !vref_o) |->
      (y_q >= CLIP_LO && y_q <= CLIP_HI && c_q >= CLIP_LO && c_q <= CLIP_HI));

  // R7: the pixel right after a line's active part opens the end code
  p_eav_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(href_o) && $past(code_en)) |-> (c_q == WORD_MAX && y_q == '0));
endmodule

// File: tb/yc422_formatter_tb_top.sv
module yc422_formatter_tb_top;
  logic       clk;
  logic       rst_n;
  logic       pix_ce;
  logic [9:0] y_in, cb_in, cr_in;
  logic       href_in, vref_in, fref_in;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [9:0] cfg_wdata;
  logic [9:0] luma_o, chroma_o, mux_o;
  logic       href_o, vref_o, fref_o;

  int n_tests = 0;
  int n_fail  = 0;

  int ay [0:159];
  int acb[0:159];
  int acr[0:159];
  bit ah [0:159];
  bit av [0:159];
  bit af [0:159];
  bit ap [0:159];
  int n_pix = 0;

  yc422_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .href_in(href_in), .vref_in(vref_in), .fref_in(fref_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .luma_o(luma_o), .chroma_o(chroma_o),
    .mux_o(mux_o), .href_o(href_o), .vref_o(vref_o), .fref_o(fref_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit hk(int k);
    return (k < 0 || k >= n_pix) ? 1'b0 : ah[k];
  endfunction

  function automatic int clipv(int x);
    return (x < 4) ? 4 : ((x > 1019) ? 1019 : x);
  endfunction

  function automatic int xyv(bit f, bit v, bit h);
    return 512 | (f << 8) | (v << 7) | (h << 6) | ((v ^ h) << 5) | ((f ^ h) << 4)
               | ((f ^ v) << 3) | ((f ^ v ^ h) << 2);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // expected word pair of pixel k under the given controls
  task automatic expect_pix(int k, bit code, bit fill, bit custom,
                            output int ec, output int ey, output string tag);
    bit h, act, eav0, eav1, sav0, sav1;
    int fc, fy;
    h    = hk(k);
    act  = h && !av[k];
    eav0 = !h && hk(k-1);
    eav1 = !h && !hk(k-1) && hk(k-2);
    sav1 = !h && hk(k+1);
    sav0 = !h && !hk(k+1) && hk(k+2);
    fc   = custom ? 'h155 : 'h200;
    fy   = custom ? 'h0AA : 'h040;
    if (code && (eav0 || sav0) && !(sav0 && (eav1))) begin
      ec = 'h3FF; ey = 0; tag = eav0 ? "R7" : "R6";
    end else if (code && eav1) begin
      ec = 0; ey = xyv(af[k], av[k], 1'b1); tag = "R8";
    end else if (code && sav1) begin
      ec = 0; ey = xyv(af[k], av[k], 1'b0); tag = "R8";
    end else if (fill && !act) begin
      ec = fc; ey = fy; tag = custom ? "R10" : "R5";
    end else begin
      ec = clipv(ap[k] ? acr[k] : acb[k]);
      ey = clipv(ay[k]);
      if (!code && (eav0 || eav1 || sav0 || sav1)) tag = "R9";
      else if (ey != ay[k] || ec != (ap[k] ? acr[k] : acb[k])) tag = "R4";
      else tag = "R2";
    end
  endtask

  task automatic push(bit h, bit v, bit f);
    int k;
    k = n_pix;
    ah[k] = h; av[k] = v; af[k] = f;
    ay[k]  = (k * 131 + 1019) % 1024;
    if (k % 5 == 0) ay[k] = k % 4;
    acb[k] = (k * 77 + 3) % 1024;
    if (k % 7 == 3) acb[k] = 1020 + k % 4;
    acr[k] = (k * 29 + 1021) % 1024;
    ap[k]  = (h && !hk(k-1)) ? 1'b0 : !((k == 0) ? 1'b0 : ap[k-1]);
    n_pix++;
  endtask

  task automatic build_frame();
    for (int li = 0; li < 4; li++) begin
      int alen;
      alen = (li == 0) ? 8 : (li == 1) ? 7 : (li == 2) ? 9 : 6;
      for (int b = 0; b < 5; b++) push(1'b0, li == 0, li >= 2);
      for (int a = 0; a < alen; a++) push(1'b1, li == 0, li >= 2);
    end
    for (int t = 0; t < 6; t++) push(1'b0, 1'b0, 1'b0);
  endtask

  task automatic cfg_write(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 10'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_pix(int n);
    bit in_range;
    in_range = (n < n_pix);
    pix_ce  = 1'b1;
    y_in    = in_range ? 10'(ay[n])  : '0;
    cb_in   = in_range ? 10'(acb[n]) : '0;
    cr_in   = in_range ? 10'(acr[n]) : '0;
    href_in = in_range ? ah[n] : 1'b0;
    vref_in = in_range ? av[n] : 1'b0;
    fref_in = in_range ? af[n] : 1'b0;
  endtask

  task automatic run(int cfgv);
    bit mode, code, fill, custom;
    int ec, ey;
    string tag;
    mode   = cfgv[0];
    code   = cfgv[1];
    fill   = cfgv[2];
    custom = (cfgv == 5) || (cfgv == 7);

    @(negedge clk);
    rst_n = 1'b0; pix_ce = 1'b0; href_in = 0; vref_in = 0; fref_in = 0;
    y_in = '0; cb_in = '0; cr_in = '0;
    repeat (2) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk("R1", {luma_o, chroma_o, mux_o}, 0);
    chk("R1", {href_o, vref_o, fref_o}, 0);
    rst_n = 1'b1;

    cfg_write(0, cfgv);
    if (custom) begin
      cfg_write(1, 'h155);
      cfg_write(2, 'h0AA);
    end
    cfg_write(3, 'h3FF);   // R10: must not alter anything

    for (int n = 0; n < n_pix + 2; n++) begin
      int k;
      k = n - 2;
      @(negedge clk);
      drive_pix(n);
      @(posedge clk); #1;
      if (k >= 0) begin
        expect_pix(k, code, fill, custom, ec, ey, tag);
        chk("R2", {href_o, vref_o, fref_o}, {ah[k], av[k], af[k]});
        if (mode) begin
          chk("R3", {luma_o, chroma_o}, 0);
          chk(tag, mux_o, ec);
        end else begin
          chk("R3", mux_o, 0);
          chk(tag, chroma_o, ec);
          chk(tag, luma_o, ey);
        end
      end
      @(negedge clk);
      pix_ce = 1'b0;
      @(posedge clk); #1;
      if (k >= 0 && mode) begin
        expect_pix(k, code, fill, custom, ec, ey, tag);
        chk(tag, mux_o, ey);   // R3 second word of the pair
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_ce = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    y_in = '0; cb_in = '0; cr_in = '0; href_in = 0; vref_in = 0; fref_in = 0;
    build_frame();
    for (int r = 0; r < 8; r++) run(r);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule